// File: doc/BRIEF.md
# Window-Select Shifter and Shuffler

A single-cycle combinational unit that reorders the bits of a W-bit word (W = 16 by default). Shifts and rotates come from one mechanism. The unit builds a staging bus almost twice the word width and picks a contiguous W-bit window out of it. The window position is set by a one-hot select decoded from the binary shift amount. Changing what fills the two halves of the staging bus turns the same window into a logical left shift, a logical right shift or a right rotate. None of these changes the relative order of the bits.

Alongside the order-preserving operations, the unit offers three fixed permutations that do change bit order:
- a half-word exchange;
- a lane reorder that swaps the two middle quarter-word lanes;
- a perfect-shuffle interleave of the low and high halves.

A 3-bit mode input selects the operation. The output follows the inputs combinationally. There is no clock or state.

Bit k of a word is element k, with element 0 the LSB.

Top module: `wsel_shifter`

## Requirements
- R1: Mode 3'b000 drives `data_o` equal to `data_i` for every shift amount.
- R2: Mode 3'b001 drives `data_o = data_i << amt_i`, with zeros filling the low bits.
- R3: Mode 3'b010 drives `data_o = data_i >> amt_i`, with zeros filling the high bits.
- R4: Mode 3'b011 rotates right, so bit i of `data_o` is bit (i + amt_i) mod W of `data_i`.
- R5: In modes 3'b001, 3'b010 and 3'b011, an `amt_i` of zero returns `data_i` unchanged.
- R6: Mode 3'b100 exchanges the halves: `data_o = {data_i[W/2-1:0], data_i[W-1:W/2]}`. `amt_i` has no effect.
- R7: Mode 3'b101 interleaves the halves: `data_o[2j] = data_i[j]` and `data_o[2j+1] = data_i[j+W/2]` for j in 0..W/2-1. `amt_i` has no effect.
- R8: Mode 3'b110 reorders lanes. A lane is W/4 bits, and lane 0 is bits W/4-1:0. Output lanes 0, 1, 2 and 3 take input lanes 0, 2, 1 and 3. `amt_i` has no effect.
- R9: Mode 3'b111 drives `data_o` to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | W | Word to reorder |
| mode_i | input | 3 | Operation select |
| amt_i | input | $clog2(W) | Binary shift or rotate amount, 0..W-1 |
| data_o | output | W | Reordered word |

## Verification
The bench builds the unit with W = 16. This makes the input space small enough to sweep every mode code against every one of the 16 shift amounts. That sweep reaches every window offset, including the one that reads the top bit of the staging bus, and the zero-amount reload on the left shift. Each mode and amount pair is driven with walking-edge patterns (all zeros, all ones, single LSB, single MSB) and with random words. This shows that the fill bits, the wrapped bits and the lane boundaries land where the arithmetic model puts them, and that the permutation modes ignore the amount.

// File: rtl/wsel_shifter.sv
module wsel_shifter #(
  parameter int W = 16
) (
  input  logic [W-1:0]         data_i,
  input  logic [2:0]           mode_i,
  input  logic [$clog2(W)-1:0] amt_i,
  output logic [W-1:0]         data_o
);

  localparam int SW = $clog2(W);
  localparam int HW = W / 2;
  localparam int LW = W / 4;

  localparam logic [2:0] M_PASS = 3'b000;
  localparam logic [2:0] M_SHL  = 3'b001;
  localparam logic [2:0] M_SHR  = 3'b010;
  localparam logic [2:0] M_ROR  = 3'b011;
  localparam logic [2:0] M_SWAP = 3'b100;
  localparam logic [2:0] M_SHUF = 3'b101;
  localparam logic [2:0] M_LANE = 3'b110;

  logic [SW-1:0]  offs;
  logic [W-1:0]   win_sel;
  logic [W-1:0]   bus_lo;
  logic [W-2:0]   bus_hi;
  logic [2*W-2:0] stage;
  logic [W-1:0]   win_out;
  logic [W-1:0]   swap_w;
  logic [W-1:0]   shuf_w;
  logic [W-1:0]   lane_w;

  // left shift reads the window W-amt up from the bottom; amt 0 wraps to offset 0
  assign offs = (mode_i == M_SHL) ? SW'(W - int'(amt_i)) : amt_i;

  genvar k, i, j;
  generate
    for (k = 0; k < W; k++) begin : g_dec
      assign win_sel[k] = (offs == SW'(k));
    end
  endgenerate

  assign bus_hi = (mode_i == M_SHL || mode_i == M_ROR) ? data_i[W-2:0] : '0;
  assign bus_lo = (mode_i == M_SHL && amt_i != '0) ? '0 : data_i;
  assign stage  = {bus_hi, bus_lo};

  generate
    for (i = 0; i < W; i++) begin : g_col
      logic [W-1:0] tap;
      for (k = 0; k < W; k++) begin : g_tap
        assign tap[k] = stage[i+k] & win_sel[k];
      end
      assign win_out[i] = |tap;
    end
  endgenerate

  assign swap_w = {data_i[HW-1:0], data_i[W-1:HW]};

  generate
    for (j = 0; j < HW; j++) begin : g_shuf
      assign shuf_w[2*j]   = data_i[j];
      assign shuf_w[2*j+1] = data_i[j+HW];
    end
  endgenerate

  assign lane_w = {data_i[4*LW-1:3*LW], data_i[2*LW-1:LW],
                   data_i[3*LW-1:2*LW], data_i[LW-1:0]};

  always_comb begin
    case (mode_i)
      M_PASS:                data_o = data_i;
      M_SHL, M_SHR, M_ROR:   data_o = win_out;
      M_SWAP:                data_o = swap_w;
      M_SHUF:                data_o = shuf_w;
      M_LANE:                data_o = lane_w;
      default:               data_o = '0;
    endcase
  end

endmodule

// File: rtl/wsel_shifter_chk.sv
module wsel_shifter_chk #(
  parameter int W = 16
) (
  input logic [W-1:0]         data_i,
  input logic [2:0]           mode_i,
  input logic [$clog2(W)-1:0] amt_i,
  input logic [W-1:0]         data_o,
  input logic [W-1:0]         win_sel
);

  always_comb begin
    if (!$isunknown({data_i, mode_i, amt_i})) begin
      // R1
      pass_equal_chk: assert (mode_i != 3'b000 || data_o == data_i)
        else $error("pass mode altered data");
      // R5
      zero_amt_chk: assert (!(mode_i inside {3'b001, 3'b010, 3'b011}) || amt_i != '0 || data_o == data_i)
        else $error("zero amount changed data");
      // R2
      shl_fill_chk: assert (mode_i != 3'b001 || amt_i == '0 || data_o[0] == 1'b0)
        else $error("left shift low fill not zero");
      // R3
      shr_fill_chk: assert (mode_i != 3'b010 || amt_i == '0 || data_o[W-1] == 1'b0)
        else $error("right shift high fill not zero");
      // R4 R6 R7 R8
      perm_pop_chk: assert (!(mode_i inside {3'b011, 3'b100, 3'b101, 3'b110}) || $countones(data_o) == $countones(data_i))
        else $error("permutation lost or gained bits");
      // R4
      win_onehot_chk: assert (!(mode_i inside {3'b001, 3'b010, 3'b011}) || $countones(win_sel) == 1)
        else $error("window select not one-hot");
      // R9
      unused_zero_chk: assert (mode_i != 3'b111 || data_o == '0)
        else $error("unused mode output not zero");
    end
  end

endmodule

bind wsel_shifter wsel_shifter_chk #(.W(W)) chk_i (
  .data_i(data_i), .mode_i(mode_i), .amt_i(amt_i), .data_o(data_o), .win_sel(win_sel)
);

// File: tb/wsel_shifter_tb_top.sv
module wsel_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int SW = 4;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0]  data_i = '0;
  logic [2:0]    mode_i = '0;
  logic [SW-1:0] amt_i = '0;
  logic [W-1:0]  data_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wsel_shifter #(.W(W)) dut_i (.data_i(data_i), .mode_i(mode_i), .amt_i(amt_i), .data_o(data_o));

  function automatic logic [W-1:0] model(input logic [2:0] m, input logic [W-1:0] d, input int s);
    logic [W-1:0] r;
    r = '0;
    case (m)
      3'd0: r = d;
      3'd1: r = d << s;
      3'd2: r = d >> s;
      3'd3: for (int b = 0; b < W; b++) r[b] = d[(b + s) % W];
      3'd4: for (int b = 0; b < W; b++) r[b] = d[(b + W/2) % W];
      3'd5: for (int b = 0; b < W/2; b++) begin r[2*b] = d[b]; r[2*b+1] = d[b + W/2]; end
      3'd6: for (int b = 0; b < W/4; b++) begin
              r[b]         = d[b];
              r[b + W/4]   = d[b + W/2];
              r[b + W/2]   = d[b + W/4];
              r[b + 3*W/4] = d[b + 3*W/4];
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag(input logic [2:0] m, input int s);
    if (s == 0 && m inside {3'd1, 3'd2, 3'd3}) return "R5";
    case (m)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [W-1:0] d, input int s);
    logic [W-1:0] exp;
    @(posedge clk);
    mode_i = m; data_i = d; amt_i = SW'(s);
    exp = model(m, d, s);
    @(negedge clk);
    checks++;
    if (data_o !== exp) begin
      errors++;
      $display("FAIL %s mode=%0d amt=%0d data=%h actual=%h expected=%h",
               tag(m, s), m, s, d, data_o, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=%0d expected<=%0d cycles", cycles, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 idle state: pass mode with zero word
    @(negedge clk);
    checks++;
    if (data_o !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", data_o, 16'h0000);
    end
    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < W; s++) begin
        apply(3'(m), 16'h0000, s);
        apply(3'(m), 16'hffff, s);
        apply(3'(m), 16'h0001, s);
        apply(3'(m), 16'h8000, s);
        apply(3'(m), 16'hfedc, s);
        for (int r = 0; r < 24; r++) apply(3'(m), W'($urandom), s);
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule